// File: doc/BRIEF.md
# Comparator Event Conditioner

This block is the digital side of a group of analog comparators, each of which has its own reference DAC. For each channel it brings the free-running comparator output into the system clock domain. It removes short glitches and turns the edges you select into a pulse one clock wide. That pulse serves as both the ADC trigger and the interrupt request. Each channel also holds the code and the reference-source select for its DAC, and drives the power enables for its analog comparator and DAC.

While the system is in Sleep or Idle, the clocked path is bypassed. The interrupt request then follows the raw comparator level directly, through combinational logic only, so it can wake a stopped clock. Any channel can ask to be stopped in Idle. One such request stops every channel in the group for as long as Idle lasts.

Software reaches the block through a simple write port. The address is split into a channel index and a two-bit register select. Each channel's event flag is visible on a status output.

Top module: `cmp_cond_top`

## Requirements
- R1: A level change on `cmp_raw[i]` that is set up before rising edge k and then held produces `evt_o[i]` high in the cycle that follows edge k+3. The path is two synchronizer flops, one stability check and one edge compare, with the default of two sync stages.
- R2: After synchronization, a comparator level that lasts only one clock is masked and produces no event. A level held for two clocks is accepted.
- R3: Each accepted edge gives `evt_o[i]` high for exactly one cycle. In run mode (neither `idle_mode` nor `sleep_mode` set), `irq_o[i]` equals `evt_o[i]`.
- R4: Control bit 3 lets rising edges of the conditioned level produce events, and control bit 4 does the same for falling edges. Control bit 2 inverts the level before edge detection. Changing the invert bit while the input is steady produces no event.
- R5: When control bit 0 (enable) is clear, `cmp_en_o[i]` and `dac_en_o[i]` are low and the channel produces no events, whatever `cmp_raw[i]` does.
- R6: While `idle_mode` is high and any channel has control bit 1 (idle stop) set, every channel's `cmp_en_o`, `dac_en_o` and `irq_o` are low. With no idle-stop bit set, enabled channels stay on in Idle.
- R7: While `sleep_mode` or `idle_mode` is high, `irq_o[i]` equals `cmp_raw[i]` XOR invert for an active channel, combinationally and with no clock, and `evt_o[i]` stays low.
- R8: `status_o[i]` is set by each event and stays set. Writing register select 2 with data bit 0 = 1 clears it. Writing 0 leaves it unchanged. When a set and a clear happen in the same cycle, the set wins.
- R9: The address is {channel, select[1:0]}: select 0 is control, 1 is the DAC code (the full data width, driven on `dac_code_o`), 2 is the status clear, and 3 is ignored. Control bits 6:5 choose the reference: 0 half supply, 1 internal, 2 external. Writing 3 stores 0.
- R10: Reset clears all control, DAC code and status registers, so every enable, pulse and flag output starts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_mode | input | 1 | System is in Idle |
| sleep_mode | input | 1 | System is in Sleep |
| cmp_raw | input | NCH | Raw asynchronous comparator outputs |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CH_W+2 | {channel index, register select} |
| cfg_wdata | input | DAC_W | Write data |
| cmp_en_o | output | NCH | Analog comparator power enable |
| dac_en_o | output | NCH | Reference DAC power enable |
| dac_code_o | output | NCH*DAC_W | DAC input codes, channel i at [i*DAC_W +: DAC_W] |
| ref_sel_o | output | 2*NCH | Reference source select, channel i at [2i +: 2] |
| evt_o | output | NCH | One-cycle ADC trigger pulse |
| irq_o | output | NCH | Interrupt request (pulse in run mode, raw level in low power) |
| status_o | output | NCH | Sticky event flags |

## Verification
The bench sends comparator pulses of exactly one and exactly two clocks. A filter that was one stage too short would let the one-clock glitch through, and one that was too long would swallow the two-clock pulse. Every expected event is checked against its exact cycle, so a wrong pipeline depth shows up as a late or early pulse. The bench changes the invert bit while the input is steady, and a design that compared against a stale polarity would give a false pulse. It gives the idle-stop request to a channel that is disabled, and a design that gated only the requesting channel would leave channel 0 powered in Idle. It also drives the comparator input in Sleep with no edge to wait for, so a wake path that went through the clocked filter would never raise the interrupt.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_DAC  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_RSVD = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      REF_HALF_SUPPLY = 2'd0,
      REF_INTERNAL    = 2'd1,
      REF_EXTERNAL    = 2'd2
   } ref_src_e;

   // packed MSB first: ref[6:5] fall[4] rise[3] invert[2] idle_stop[1] enable[0]
   typedef struct packed {
      ref_src_e ref_src;
      logic     fall_en;
      logic     rise_en;
      logic     invert;
      logic     idle_stop;
      logic     enable;
   } chan_ctrl_t;

   localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

   function automatic chan_ctrl_t decode_ctrl(logic [CTRL_W-1:0] w);
      chan_ctrl_t c;
      c.enable    = w[0];
      c.idle_stop = w[1];
      c.invert    = w[2];
      c.rise_en   = w[3];
      c.fall_en   = w[4];
      case (w[6:5])
         2'd1:    c.ref_src = REF_INTERNAL;
         2'd2:    c.ref_src = REF_EXTERNAL;
         default: c.ref_src = REF_HALF_SUPPLY;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/cmp_sync_filter.sv
module cmp_sync_filter #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic raw_i,
   output logic filt_o
);

   logic [STAGES-1:0] sync_q;
   logic              sync_out;
   logic              samp_q;
   logic              filt_q;

   // synchronizer chain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sync_q <= '0;
      else if (clr) sync_q <= '0;
      else          sync_q <= {sync_q[STAGES-2:0], raw_i};
   end

   assign sync_out = sync_q[STAGES-1];

   // a new level is taken only after two equal samples in a row
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= 1'b0;
         filt_q <= 1'b0;
      end else if (clr) begin
         samp_q <= 1'b0;
         filt_q <= 1'b0;
      end else begin
         samp_q <= sync_out;
         if (sync_out == samp_q) filt_q <= sync_out;
      end
   end

   assign filt_o = filt_q;

   // R2: a change of the filtered level needs two matching synchronized samples
   assert_filter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((filt_q != $past(filt_q)) && !$past(clr)) |->
         (($past(sync_out) == filt_q) && ($past(samp_q) == filt_q)));

endmodule

// File: rtl/cmp_edge_gen.sv
module cmp_edge_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic filt_i,
   input  logic invert,
   input  logic rise_en,
   input  logic fall_en,
   output logic pulse_o
);

   logic filt_d;
   logic cur_lvl;
   logic prv_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   filt_d <= 1'b0;
      else if (clr) filt_d <= 1'b0;
      else          filt_d <= filt_i;
   end

   // both samples see the same polarity, so toggling invert makes no edge
   assign cur_lvl = filt_i ^ invert;
   assign prv_lvl = filt_d ^ invert;

   assign pulse_o = (rise_en &  cur_lvl & ~prv_lvl) |
                    (fall_en & ~cur_lvl &  prv_lvl);

   // R3: pulses never last two cycles
   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/cmp_chan_regs.sv
module cmp_chan_regs
   import cmp_cond_pkg::*;
#(
   parameter int unsigned DAC_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic             dac_we,
   input  logic             stat_we,
   input  logic [DAC_W-1:0] wdata,
   input  logic             evt_i,
   output chan_ctrl_t       ctrl_o,
   output logic [DAC_W-1:0] dac_o,
   output logic             sts_o
);

   chan_ctrl_t       ctrl_q;
   logic [DAC_W-1:0] dac_q;
   logic             sts_q;
   logic             clr_req;

   assign clr_req = stat_we & wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dac_q  <= '0;
      end else begin
         if (ctrl_we) ctrl_q <= decode_ctrl(wdata[CTRL_W-1:0]);
         if (dac_we)  dac_q  <= wdata;
      end
   end

   // sticky flag, set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sts_q <= 1'b0;
      else if (evt_i)   sts_q <= 1'b1;
      else if (clr_req) sts_q <= 1'b0;
   end

   assign ctrl_o = ctrl_q;
   assign dac_o  = dac_q;
   assign sts_o  = sts_q;

   // R8: every event leaves the flag set
   assert_status_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> sts_q);

   // R8: without a clear request the flag does not drop
   assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && !clr_req) |=> sts_q);

endmodule

// File: rtl/cmp_cond_top.sv
module cmp_cond_top
   import cmp_cond_pkg::*;
#(
   parameter int unsigned NCH         = 2,
   parameter int unsigned DAC_W       = 10,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CH_W       = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned AW         = CH_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 idle_mode,
   input  logic                 sleep_mode,
   input  logic [NCH-1:0]       cmp_raw,
   input  logic                 cfg_we,
   input  logic [AW-1:0]        cfg_addr,
   input  logic [DAC_W-1:0]     cfg_wdata,
   output logic [NCH-1:0]       cmp_en_o,
   output logic [NCH-1:0]       dac_en_o,
   output logic [NCH*DAC_W-1:0] dac_code_o,
   output logic [2*NCH-1:0]     ref_sel_o,
   output logic [NCH-1:0]       evt_o,
   output logic [NCH-1:0]       irq_o,
   output logic [NCH-1:0]       status_o
);

   // elaboration-time parameter checks
   if (NCH < 1) begin : g_bad_nch
      initial $error("cmp_cond_top: NCH must be at least 1");
   end
   if (DAC_W < CTRL_W) begin : g_bad_dacw
      initial $error("cmp_cond_top: DAC_W must hold the control word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $error("cmp_cond_top: SYNC_STAGES must be at least 2");
   end

   reg_sel_e       sel;
   logic [NCH-1:0] istop_vec;
   logic           grp_stop;
   logic           low_power;

   assign sel       = reg_sel_e'(cfg_addr[1:0]);
   assign low_power = idle_mode | sleep_mode;
   assign grp_stop  = idle_mode & (|istop_vec);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      chan_ctrl_t       ctrl;
      logic [DAC_W-1:0] dac_code;
      logic             hit;
      logic             active;
      logic             filt;
      logic             edge_p;
      logic             evt;

      assign hit = cfg_we && (cfg_addr[AW-1:2] == CH_W'(i));

      cmp_chan_regs #(.DAC_W(DAC_W)) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctrl_we (hit && (sel == SEL_CTRL)),
         .dac_we  (hit && (sel == SEL_DAC)),
         .stat_we (hit && (sel == SEL_STAT)),
         .wdata   (cfg_wdata),
         .evt_i   (evt),
         .ctrl_o  (ctrl),
         .dac_o   (dac_code),
         .sts_o   (status_o[i])
      );

      assign active       = ctrl.enable & ~grp_stop;
      assign istop_vec[i] = ctrl.idle_stop;

      cmp_sync_filter #(.STAGES(SYNC_STAGES)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (~active),
         .raw_i  (cmp_raw[i]),
         .filt_o (filt)
      );

      cmp_edge_gen u_edge (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (~active),
         .filt_i  (filt),
         .invert  (ctrl.invert),
         .rise_en (ctrl.rise_en),
         .fall_en (ctrl.fall_en),
         .pulse_o (edge_p)
      );

      assign evt = edge_p & active & ~low_power;

      assign evt_o[i]    = evt;
      assign irq_o[i]    = low_power ? (active & (cmp_raw[i] ^ ctrl.invert)) : evt;
      assign cmp_en_o[i] = active;
      assign dac_en_o[i] = active;
      assign dac_code_o[i*DAC_W +: DAC_W] = dac_code;
      assign ref_sel_o[2*i +: 2]          = ctrl.ref_src;

      // R5: a disabled channel is powered down and silent
      assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl.enable |-> (!cmp_en_o[i] && !dac_en_o[i] && !evt_o[i]));

      // R7: no clocked events while in a low-power mode
      assert_lowpow_no_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
         low_power |-> !evt_o[i]);
   end

   // R6: one idle-stop request shuts the whole group in Idle
   assert_group_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_mode && (|istop_vec)) |-> ((cmp_en_o == '0) && (dac_en_o == '0) && (irq_o == '0)));

endmodule

// File: tb/sim_cmp_cond_top.sv
module sim_cmp_cond_top;

   localparam int CLK_P = 10;
   localparam int NCH   = 2;
   localparam int DAC_W = 10;
   localparam int AW    = 3;
   localparam int LAT   = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               idle_mode = 1'b0;
   logic               sleep_mode = 1'b0;
   logic [NCH-1:0]     cmp_raw = '0;
   logic               cfg_we = 1'b0;
   logic [AW-1:0]      cfg_addr = '0;
   logic [DAC_W-1:0]   cfg_wdata = '0;
   logic [NCH-1:0]     cmp_en_o, dac_en_o, evt_o, irq_o, status_o;
   logic [NCH*DAC_W-1:0] dac_code_o;
   logic [2*NCH-1:0]   ref_sel_o;

   cmp_cond_top #(.NCH(NCH), .DAC_W(DAC_W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .idle_mode(idle_mode), .sleep_mode(sleep_mode),
      .cmp_raw(cmp_raw), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cmp_en_o(cmp_en_o), .dac_en_o(dac_en_o), .dac_code_o(dac_code_o),
      .ref_sel_o(ref_sel_o), .evt_o(evt_o), .irq_o(irq_o), .status_o(status_o)
   );

   always #(CLK_P/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct { int ch; int cyc; } exp_t;
   exp_t exp_q[$];

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // driver: change one raw input, optionally queue the event it must cause
   task automatic put_raw(int ch, bit v, bit want_evt);
      exp_t e;
      @(negedge clk);
      cmp_raw[ch] = v;
      if (want_evt) begin
         e.ch  = ch;
         e.cyc = cyc + LAT;
         exp_q.push_back(e);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = AW'(a);
      cfg_wdata = DAC_W'(d);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pop expected events as the design produces them
   logic [NCH-1:0] evt_prev = '0;
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         for (int c = 0; c < NCH; c++) begin
            if (!idle_mode && !sleep_mode && (evt_o[c] || irq_o[c]))
               check("R3 irq equals evt in run mode", irq_o[c], evt_o[c]);
            if (evt_o[c] && evt_prev[c])
               check("R3 pulse width one cycle", 32'd2, 32'd1);
            if (evt_o[c]) begin
               if (exp_q.size() == 0) begin
                  total++;
                  bad++;
                  $display("FAIL R2/R4/R5 unexpected event ch%0d cycle %0d actual=1 expected=0", c, cyc);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  check("R1 event channel", c, e.ch);
                  check("R1 event cycle", cyc, e.cyc);
               end
            end
         end
         evt_prev = evt_o;
      end
   end

   initial begin
      #(CLK_P * 50000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      settle(3);
      rst_n = 1'b1;
      #2;
      // R10 reset state
      check("R10 cmp_en after reset", cmp_en_o, 0);
      check("R10 dac_en after reset", dac_en_o, 0);
      check("R10 status after reset", status_o, 0);
      check("R10 dac code after reset", dac_code_o, 0);
      check("R10 evt after reset", evt_o, 0);

      // R9 register map: ch0 enable, rise+fall, external ref
      wr(0, 'h59);
      wr(1, 'h155);
      wr(4, 'h60);
      #2;
      check("R9 dac code ch0", dac_code_o[DAC_W-1:0], 'h155);
      check("R9 ref select ch0 external", ref_sel_o[1:0], 2);
      check("R9 ref select 3 stored as 0", ref_sel_o[3:2], 0);
      check("R5 ch1 disabled comparator", cmp_en_o[1], 0);
      check("R5 ch0 enabled comparator", cmp_en_o[0], 1);
      check("R5 ch0 enabled dac", dac_en_o[0], 1);
      wr(3, 'h3FF);
      #2;
      check("R9 reserved select ignored (dac)", dac_code_o[DAC_W-1:0], 'h155);
      check("R9 reserved select ignored (enable)", cmp_en_o[0], 1);
      settle(6);

      // R1 latency, both edges
      put_raw(0, 1'b1, 1'b1); settle(8);
      put_raw(0, 1'b0, 1'b1); settle(8);

      // R2 one-cycle glitch masked
      put_raw(0, 1'b1, 1'b0);
      put_raw(0, 1'b0, 1'b0);
      settle(8);

      // R2 two-cycle pulse accepted
      put_raw(0, 1'b1, 1'b1);
      settle(1);
      put_raw(0, 1'b0, 1'b1);
      settle(8);

      // R8 sticky status and write-one-to-clear
      #2;
      check("R8 status set by event", status_o[0], 1);
      check("R8 status ch1 untouched", status_o[1], 0);
      wr(2, 0);
      #2;
      check("R8 write zero keeps status", status_o[0], 1);
      wr(2, 1);
      #2;
      check("R8 write one clears status", status_o[0], 0);

      // R4 rising only
      wr(0, 'h49);
      put_raw(0, 1'b1, 1'b1); settle(8);
      put_raw(0, 1'b0, 1'b0); settle(8);
      // R4 inverted, rising only: raw falling gives the event
      wr(0, 'h4D);
      settle(4);
      put_raw(0, 1'b1, 1'b0); settle(8);
      put_raw(0, 1'b0, 1'b1); settle(8);
      // R4 falling only
      wr(0, 'h51);
      settle(4);
      put_raw(0, 1'b1, 1'b0); settle(8);
      put_raw(0, 1'b0, 1'b1); settle(8);

      // R5 disabled channel
      wr(0, 'h48);
      #2;
      check("R5 disabled comparator enable", cmp_en_o[0], 0);
      check("R5 disabled dac enable", dac_en_o[0], 0);
      put_raw(0, 1'b1, 1'b0); settle(8);
      put_raw(0, 1'b0, 1'b0); settle(8);
      wr(0, 'h59);
      settle(6);

      // R6 idle stop requested by disabled ch1 stops ch0
      wr(4, 'h02);
      @(negedge clk);
      idle_mode = 1'b1;
      #2;
      check("R6 group stop comparator ch0", cmp_en_o[0], 0);
      check("R6 group stop dac ch0", dac_en_o[0], 0);
      put_raw(0, 1'b1, 1'b0);
      #2;
      check("R6 group stop masks wake", irq_o[0], 0);
      put_raw(0, 1'b0, 1'b0);
      @(negedge clk);
      idle_mode = 1'b0;
      #2;
      check("R6 run restores comparator", cmp_en_o[0], 1);
      settle(6);

      // R7 sleep wake path
      wr(4, 'h00);
      @(negedge clk);
      sleep_mode = 1'b1;
      put_raw(0, 1'b1, 1'b0);
      #2;
      check("R7 sleep irq follows raw high", irq_o[0], 1);
      check("R7 sleep no evt", evt_o[0], 0);
      put_raw(0, 1'b0, 1'b0);
      #2;
      check("R7 sleep irq follows raw low", irq_o[0], 0);
      wr(0, 'h5D);
      #2;
      check("R7 sleep irq with invert", irq_o[0], 1);
      wr(0, 'h59);
      settle(6);
      sleep_mode = 1'b0;
      settle(4);

      // R6 idle without stop request keeps channel alive
      @(negedge clk);
      idle_mode = 1'b1;
      put_raw(0, 1'b1, 1'b0);
      #2;
      check("R6 idle without stop keeps comparator", cmp_en_o[0], 1);
      check("R7 idle irq follows raw", irq_o[0], 1);
      put_raw(0, 1'b0, 1'b0);
      settle(6);
      idle_mode = 1'b0;

      settle(10);
      check("R1 all expected events seen", exp_q.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule